// File: doc/BRIEF.md
# One-Wire Bus Timing Master

This block is the timing master for a single open-drain one-wire bus. It takes one command at a time and turns it into bus slots: a reset with presence detect, a single write slot, a single read slot, a combined "touch" slot, or eight slots that move one byte least significant bit first. It only ever pulls the line low or lets it go. The pull-up and the line level come from outside.

All slot phases are counted in microseconds. A clock divider turns `CLKS_PER_US` clock cycles into one microsecond tick. The divider restarts at the start of every slot, so each phase lasts an exact number of clock cycles. `DELAY_SCALE` multiplies every phase length. The bus input passes through a two-flop synchronizer before it is sampled. A command is given with `cmd_valid` while `busy` is low. Completion is a one-cycle `done` pulse, and the result registers are updated in that same cycle.

Command codes on `cmd_op`: 0 = bus reset, 1 = write bit, 2 = read bit, 3 = write byte, 4 = read byte, 5 = touch bit. Codes 6 and 7 are not commands.

Top module: `owm_master`

## Requirements
- R1: After reset, `bus_drive_low`, `busy`, `done`, `rd_bit`, `rd_byte` and `presence` are all 0.
- R2: A write-1 slot pulls the line low for 6 us, then releases it for 64 us. One us is `CLKS_PER_US` times `DELAY_SCALE` clock cycles.
- R3: A write-0 slot pulls the line low for 60 us, then releases it for 10 us.
- R4: A read slot pulls the line low for 6 us and releases it for 64 us. The synchronized line is sampled 9 us after release, and a read-bit command returns that sample on `rd_bit`.
- R5: A bus reset pulls the line low for 480 us and releases it for 480 us. The line is sampled 70 us after release, and `presence` is set to 1 when that sample is low (a device answered) or to 0 when it is high.
- R6: A write-byte command sends eight slots, `cmd_byte` bit 0 first. A 1 bit gives a write-1 slot and a 0 bit gives a write-0 slot. Each slot starts one clock cycle after the previous one ends.
- R7: A read-byte command performs eight read slots. The first sample lands in `rd_byte` bit 0 and the last in bit 7.
- R8: A touch command with `cmd_bit` = 1 performs a read slot and returns the sample on `rd_bit`. With `cmd_bit` = 0 it performs a write-0 slot and returns 0 on `rd_bit`.
- R9: `busy` rises in the cycle after a command is accepted and falls in the cycle when `done` pulses for one cycle. The line is only pulled low while `busy` is high. A command of N slots of total length S cycles ends with `done` S + N cycles after the accepting edge.
- R10: A `cmd_valid` given while `busy` is high is ignored: no extra slot, no change to the running transfer.
- R11: A `cmd_valid` with code 6 or 7 is ignored: `busy` stays low, no slot is sent and no `done` follows.
- R12: `DELAY_SCALE` stretches every phase by its factor. For example, with 1 cycle per us and a scale of 3, a write-0 slot is low for 180 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command request, accepted when `busy` is low |
| cmd_op | input | 3 | Command code (0..5) |
| cmd_bit | input | 1 | Bit value for write-bit and touch commands |
| cmd_byte | input | 8 | Byte for write-byte commands |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_bit | output | 1 | Result of read-bit and touch commands |
| rd_byte | output | 8 | Result of read-byte commands |
| presence | output | 1 | 1 when the last bus reset saw a presence answer |
| bus_drive_low | output | 1 | 1 pulls the bus low, 0 releases it |
| bus_in | input | 1 | Level of the bus line (asynchronous) |

## Verification
Bytes with mixed bits (for example 0xA5) show whether the bits go out least significant bit first, because the low-pulse widths reveal the bit order. Slave answers that differ bit by bit, such as 0x3C, catch a reversed or shifted read assembly. Reset is tried with and without a presence answer, and touch with both values, to separate the read path from the write-0 path. Commands are also issued in the middle of a transfer and with unused codes, to confirm they leave the bus untouched. A second instance with a different scale and divider checks that phase lengths follow both parameters.

// File: rtl/owm_pkg.sv
// Shared types and slot timing constants for the one-wire master.
// Assumes all times are in microseconds before scaling.
package owm_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        OP_RESET = 3'd0,
        OP_WBIT  = 3'd1,
        OP_RBIT  = 3'd2,
        OP_WBYTE = 3'd3,
        OP_RBYTE = 3'd4,
        OP_TOUCH = 3'd5
    } op_e;

    typedef enum logic [1:0] {
        SL_W1  = 2'd0,
        SL_W0  = 2'd1,
        SL_RD  = 2'd2,
        SL_RST = 2'd3
    } slot_e;

    localparam int W1_LOW_US  = 6;
    localparam int W1_REL_US  = 64;
    localparam int W0_LOW_US  = 60;
    localparam int W0_REL_US  = 10;
    localparam int RD_LOW_US  = 6;
    localparam int RD_SMP_US  = 9;
    localparam int RD_REL_US  = 64;
    localparam int RST_LOW_US = 480;
    localparam int RST_SMP_US = 70;
    localparam int RST_REL_US = 480;

endpackage

// File: rtl/owm_us_tick.sv
// Microsecond tick divider. Pulses tick once every CLKS_PER_US cycles.
// clr restarts the count so the first tick comes CLKS_PER_US cycles later.
module owm_us_tick #(
    parameter int CLKS_PER_US = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);

    generate
        if (CLKS_PER_US <= 1) begin : g_every
            assign tick = 1'b1;
        end else begin : g_div
            localparam int CW = $clog2(CLKS_PER_US);
            localparam logic [CW-1:0] LAST = CW'(CLKS_PER_US - 1);
            logic [CW-1:0] cnt_q;

            // count cycles within one microsecond
            always_ff @(posedge clk) begin
                if (!rst_n || clr)      cnt_q <= '0;
                else if (cnt_q == LAST) cnt_q <= '0;
                else                    cnt_q <= cnt_q + CW'(1);
            end

            assign tick = (cnt_q == LAST);

            AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick); // R12
        end
    endgenerate

endmodule

// File: rtl/owm_sync.sv
// Two-flop synchronizer for the asynchronous bus level. Resets to the
// idle (high) level of a pulled-up line.
module owm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] chain_q;

    // shift the line level through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], din};
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/owm_slot.sv
// Single-slot engine: a low phase, then a release phase with an optional
// sample point. Phase lengths come from the slot kind and DELAY_SCALE.
// Assumes start arrives only while idle and the tick divider is cleared
// on start.
module owm_slot
    import owm_pkg::*;
#(
    parameter int DELAY_SCALE = 1
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  tick,
    input  logic  start,
    input  slot_e kind,
    input  logic  line_s,
    output logic  drive_low,
    output logic  slot_done,
    output logic  sample
);

    localparam int MAX_US = RST_LOW_US * DELAY_SCALE;
    localparam int UW     = $clog2(MAX_US + 1);

    typedef enum logic [1:0] {E_IDLE, E_LOW, E_REL} est_e;

    est_e          st_q;
    slot_e         kind_q;
    logic [UW-1:0] us_q;
    logic [UW-1:0] low_len, rel_len, smp_at;
    logic          has_smp;

    // phase lengths for the latched slot kind
    always_comb begin
        has_smp = 1'b0;
        smp_at  = UW'(1);
        case (kind_q)
            SL_W1: begin
                low_len = UW'(W1_LOW_US * DELAY_SCALE);
                rel_len = UW'(W1_REL_US * DELAY_SCALE);
            end
            SL_W0: begin
                low_len = UW'(W0_LOW_US * DELAY_SCALE);
                rel_len = UW'(W0_REL_US * DELAY_SCALE);
            end
            SL_RD: begin
                low_len = UW'(RD_LOW_US * DELAY_SCALE);
                rel_len = UW'(RD_REL_US * DELAY_SCALE);
                smp_at  = UW'(RD_SMP_US * DELAY_SCALE);
                has_smp = 1'b1;
            end
            default: begin
                low_len = UW'(RST_LOW_US * DELAY_SCALE);
                rel_len = UW'(RST_REL_US * DELAY_SCALE);
                smp_at  = UW'(RST_SMP_US * DELAY_SCALE);
                has_smp = 1'b1;
            end
        endcase
    end

    // slot sequencer: low phase, release phase, sample, done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= E_IDLE;
            kind_q    <= SL_W1;
            us_q      <= '0;
            drive_low <= 1'b0;
            slot_done <= 1'b0;
            sample    <= 1'b1;
        end else begin
            slot_done <= 1'b0;
            case (st_q)
                E_IDLE: begin
                    if (start) begin
                        st_q      <= E_LOW;
                        kind_q    <= kind;
                        us_q      <= '0;
                        drive_low <= 1'b1;
                    end
                end
                E_LOW: begin
                    if (tick) begin
                        if (us_q == low_len - UW'(1)) begin
                            st_q      <= E_REL;
                            us_q      <= '0;
                            drive_low <= 1'b0;
                        end else begin
                            us_q <= us_q + UW'(1);
                        end
                    end
                end
                E_REL: begin
                    if (tick) begin
                        if (has_smp && us_q == smp_at - UW'(1)) sample <= line_s;
                        if (us_q == rel_len - UW'(1)) begin
                            st_q      <= E_IDLE;
                            slot_done <= 1'b1;
                        end else begin
                            us_q <= us_q + UW'(1);
                        end
                    end
                end
                default: st_q <= E_IDLE;
            endcase
        end
    end

    AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (st_q == E_IDLE)); // R6
    AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        slot_done |-> !drive_low); // R2

endmodule

// File: rtl/owm_master.sv
// One-wire bus timing master. Accepts one command at a time, splits it
// into slots for the slot engine, and collects the sampled results.
// Assumes an external pull-up on the bus and an asynchronous bus_in.
module owm_master
    import owm_pkg::*;
#(
    parameter int CLKS_PER_US = 100,
    parameter int DELAY_SCALE = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic              cmd_bit,
    input  logic [BYTE_W-1:0] cmd_byte,
    output logic              busy,
    output logic              done,
    output logic              rd_bit,
    output logic [BYTE_W-1:0] rd_byte,
    output logic              presence,
    output logic              bus_drive_low,
    input  logic              bus_in
);

    localparam int CW = $clog2(BYTE_W);

    logic              accept, start, last, tick, line_s, slot_done, smp;
    slot_e             kind;
    logic [2:0]        op_q;
    logic [BYTE_W-1:0] sh_q, res_q, res_nx;
    logic [CW-1:0]     cnt_q, nb_q;

    function automatic slot_e pick(input logic [2:0] op, input logic b);
        case (op)
            OP_RESET: pick = SL_RST;
            OP_RBIT,
            OP_RBYTE: pick = SL_RD;
            OP_TOUCH: pick = b ? SL_RD : SL_W0;
            default:  pick = b ? SL_W1 : SL_W0;
        endcase
    endfunction

    // command acceptance and next-slot launch
    always_comb begin
        accept = cmd_valid && !busy && (cmd_op <= OP_TOUCH);
        last   = (cnt_q == nb_q);
        start  = accept || (busy && slot_done && !last);
        res_nx = {smp, res_q[BYTE_W-1:1]};
        if (accept) kind = pick(cmd_op, (cmd_op == OP_WBYTE) ? cmd_byte[0] : cmd_bit);
        else        kind = pick(op_q, sh_q[1]);
    end

    owm_us_tick #(.CLKS_PER_US(CLKS_PER_US)) u_tick (
        .clk(clk), .rst_n(rst_n), .clr(start), .tick(tick)
    );

    owm_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(bus_in), .dout(line_s)
    );

    owm_slot #(.DELAY_SCALE(DELAY_SCALE)) u_slot (
        .clk(clk), .rst_n(rst_n), .tick(tick), .start(start), .kind(kind),
        .line_s(line_s), .drive_low(bus_drive_low), .slot_done(slot_done),
        .sample(smp)
    );

    // command state, bit shifting and result capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            done     <= 1'b0;
            op_q     <= OP_RESET;
            sh_q     <= '0;
            res_q    <= '0;
            cnt_q    <= '0;
            nb_q     <= '0;
            rd_bit   <= 1'b0;
            rd_byte  <= '0;
            presence <= 1'b0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                busy  <= 1'b1;
                op_q  <= cmd_op;
                sh_q  <= (cmd_op == OP_WBYTE) ? cmd_byte : {{(BYTE_W-1){1'b0}}, cmd_bit};
                res_q <= '0;
                cnt_q <= '0;
                nb_q  <= (cmd_op == OP_WBYTE || cmd_op == OP_RBYTE) ? CW'(BYTE_W - 1) : '0;
            end else if (busy && slot_done) begin
                res_q <= res_nx;
                sh_q  <= sh_q >> 1;
                cnt_q <= cnt_q + CW'(1);
                if (last) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                    case (op_q)
                        OP_RESET: presence <= !smp;
                        OP_RBIT:  rd_bit   <= smp;
                        OP_TOUCH: rd_bit   <= sh_q[0] ? smp : 1'b0;
                        OP_RBYTE: rd_byte  <= res_nx;
                        default:  ;
                    endcase
                end
            end
        end
    end

    AST_DRIVE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        bus_drive_low |-> busy); // R9
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_BUSY_FALL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R9
    AST_BAD_OP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_valid && cmd_op > 3'd5) |=> !busy); // R11

endmodule

// File: tb/tb_owm_master.sv
module tb_owm_master;

    localparam int CPU = 2;
    localparam int SC  = 1;
    localparam int U   = CPU * SC;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_op = 3'd0;
    logic       cmd_bit = 1'b0;
    logic [7:0] cmd_byte = 8'd0;
    logic       busy, done, rd_bit, presence, bus_drive_low, bus_in;
    logic [7:0] rd_byte;

    logic       cmd_valid2 = 1'b0;
    logic       cmd_bit2 = 1'b0;
    logic       busy2, done2, rd_bit2, presence2, drive2, bus_in2;
    logic [7:0] rd_byte2;

    always #2 clk = ~clk;

    owm_master #(.CLKS_PER_US(CPU), .DELAY_SCALE(SC)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_bit(cmd_bit), .cmd_byte(cmd_byte), .busy(busy), .done(done),
        .rd_bit(rd_bit), .rd_byte(rd_byte), .presence(presence),
        .bus_drive_low(bus_drive_low), .bus_in(bus_in)
    );

    owm_master #(.CLKS_PER_US(1), .DELAY_SCALE(3)) dut_x3 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid2), .cmd_op(3'd1),
        .cmd_bit(cmd_bit2), .cmd_byte(8'd0), .busy(busy2), .done(done2),
        .rd_bit(rd_bit2), .rd_byte(rd_byte2), .presence(presence2),
        .bus_drive_low(drive2), .bus_in(bus_in2)
    );

    int total = 0;
    int fails = 0;

    // bus and slave model state
    logic slave_low = 1'b0;
    logic [7:0] slave_bits = 8'd0;
    logic slave_pres = 1'b0;
    int sl_idx = 0, sl_wait = 0, sl_cnt = 0;
    int np = 0, run_cnt = 0;
    int lw [16];
    int gp [16];
    logic prev_drv = 1'b0;
    int lcnt2 = 0, lw2 = 0;

    assign bus_in  = ~bus_drive_low & ~slave_low;
    assign bus_in2 = ~drive2;

    // pulse recorder and slave responder
    always @(negedge clk) begin
        if (sl_wait > 0) begin
            sl_wait = sl_wait - 1;
            if (sl_wait == 0) sl_cnt = 240;
        end else if (sl_cnt > 0) begin
            sl_cnt = sl_cnt - 1;
        end
        if (bus_drive_low != prev_drv) begin
            if (prev_drv) begin
                if (np < 16) lw[np] = run_cnt;
                np = np + 1;
                if (run_cnt == 6 * U) begin
                    if (sl_idx < 8 && !slave_bits[sl_idx]) sl_cnt = 40;
                    sl_idx = sl_idx + 1;
                end else if (run_cnt == 480 * U && slave_pres) begin
                    sl_wait = 60;
                end
            end else begin
                if (np > 0 && np <= 16) gp[np-1] = run_cnt;
            end
            run_cnt = 1;
        end else begin
            run_cnt = run_cnt + 1;
        end
        prev_drv  = bus_drive_low;
        slave_low = (sl_cnt > 0);
        if (drive2) lcnt2 = lcnt2 + 1;
        else if (lcnt2 != 0) begin lw2 = lcnt2; lcnt2 = 0; end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total = total + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // slot kind codes: 0 reset, 1 write-1, 2 write-0, 3 read
    function automatic int kind_of(input int op, input logic b);
        case (op)
            0: return 0;
            2, 4: return 3;
            5: return b ? 3 : 2;
            default: return b ? 1 : 2;
        endcase
    endfunction
    function automatic int low_us(input int k);
        case (k) 0: return 480; 1: return 6; 2: return 60; default: return 6; endcase
    endfunction
    function automatic int rel_us(input int k);
        case (k) 0: return 480; 1: return 64; 2: return 10; default: return 64; endcase
    endfunction
    function automatic string tag(input int k);
        case (k) 0: return "R5"; 1: return "R2"; 2: return "R3"; default: return "R4"; endcase
    endfunction

    task automatic run_cmd(input logic [2:0] op, input logic b, input logic [7:0] byt,
                           input bit inject, output int cyc);
        @(negedge clk); #1;
        np = 0; sl_idx = 0;
        cmd_valid = 1'b1; cmd_op = op; cmd_bit = b; cmd_byte = byt;
        @(negedge clk); #1;
        cmd_valid = 1'b0;
        chk(busy == 1'b1, "R9 busy after accept", int'(busy), 1);
        cyc = 0;
        while (!done && cyc < 30000) begin
            @(negedge clk); #1;
            cyc = cyc + 1;
            if (inject && cyc == 50) begin
                cmd_valid = 1'b1; cmd_op = 3'd4;
            end else begin
                cmd_valid = 1'b0;
            end
        end
        cmd_valid = 1'b0;
        chk(busy == 1'b0, "R9 busy low in done cycle", int'(busy), 0);
        chk(bus_drive_low == 1'b0, "R9 bus released at done", int'(bus_drive_low), 0);
        @(negedge clk); #1;
        chk(done == 1'b0, "R9 done one cycle", int'(done), 0);
    endtask

    task automatic verify(input int op, input logic b, input logic [7:0] byt, input int cyc);
        int n, texp, k;
        logic bi;
        n = (op == 3 || op == 4) ? 8 : 1;
        texp = n;
        chk(np == n, (op == 3) ? "R6 slot count" : (op == 4) ? "R7 slot count" : "R9 slot count", np, n);
        for (int i = 0; i < n && i < 16; i++) begin
            bi = (op == 3) ? byt[i] : b;
            k = kind_of(op, bi);
            chk(lw[i] == low_us(k) * U, (op == 3) ? "R6 low width / bit order" : tag(k),
                lw[i], low_us(k) * U);
            if (i < n - 1)
                chk(gp[i] == rel_us(k) * U + 1, (op == 3) ? "R6 release gap" : "R7 release gap",
                    gp[i], rel_us(k) * U + 1);
            texp = texp + (low_us(k) + rel_us(k)) * U;
        end
        chk(cyc == texp, "R9 command duration", cyc, texp);
        case (op)
            0: chk(presence == slave_pres, "R5 presence", int'(presence), int'(slave_pres));
            2: chk(rd_bit == slave_bits[0], "R4 read bit", int'(rd_bit), int'(slave_bits[0]));
            4: chk(rd_byte == slave_bits, "R7 read byte order", int'(rd_byte), int'(slave_bits));
            5: chk(rd_bit == (b & slave_bits[0]), "R8 touch result", int'(rd_bit), int'(b & slave_bits[0]));
            default: ;
        endcase
    endtask

    task automatic do_op(input int op, input logic b, input logic [7:0] byt,
                         input logic [7:0] sbits, input logic spres);
        int cyc;
        slave_bits = sbits; slave_pres = spres;
        run_cmd(3'(op), b, byt, 1'b0, cyc);
        verify(op, b, byt, cyc);
    endtask

    task automatic do_scaled(input logic b);
        int cyc, exp_low, exp_cyc;
        @(negedge clk); #1;
        cmd_valid2 = 1'b1; cmd_bit2 = b;
        @(negedge clk); #1;
        cmd_valid2 = 1'b0;
        cyc = 0;
        while (!done2 && cyc < 30000) begin
            @(negedge clk); #1;
            cyc = cyc + 1;
        end
        @(negedge clk); #1;
        exp_low = (b ? 6 : 60) * 3;
        exp_cyc = (b ? 70 : 70) * 3 + 1;
        chk(lw2 == exp_low, "R12 scaled low width", lw2, exp_low);
        chk(cyc == exp_cyc, "R12 scaled duration", cyc, exp_cyc);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails = fails + 1;
        total = total + 1;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        int cyc, np_keep;
        logic [7:0] keep_byte;
        bit saw_done;
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(bus_drive_low == 0, "R1 drive after reset", int'(bus_drive_low), 0);
        chk(busy == 0, "R1 busy after reset", int'(busy), 0);
        chk(done == 0, "R1 done after reset", int'(done), 0);
        chk(rd_bit == 0 && presence == 0, "R1 result bits after reset", int'({rd_bit, presence}), 0);
        chk(rd_byte == 0, "R1 rd_byte after reset", int'(rd_byte), 0);

        do_op(0, 1'b0, 8'h00, 8'hFF, 1'b1);   // R5 device present
        do_op(0, 1'b0, 8'h00, 8'hFF, 1'b0);   // R5 no device
        do_op(1, 1'b1, 8'h00, 8'hFF, 1'b0);   // R2
        do_op(1, 1'b0, 8'h00, 8'hFF, 1'b0);   // R3
        do_op(2, 1'b1, 8'h00, 8'h00, 1'b0);   // R4 slave answers 0
        do_op(2, 1'b1, 8'h00, 8'h01, 1'b0);   // R4 slave answers 1
        do_op(3, 1'b0, 8'hA5, 8'hFF, 1'b0);   // R6
        do_op(3, 1'b0, 8'h01, 8'hFF, 1'b0);   // R6 single one at bit 0
        do_op(4, 1'b1, 8'h00, 8'h3C, 1'b0);   // R7
        do_op(4, 1'b1, 8'h00, 8'h80, 1'b0);   // R7 last bit only
        do_op(5, 1'b1, 8'h00, 8'h00, 1'b0);   // R8 touch 1, slave 0
        do_op(5, 1'b1, 8'h00, 8'h01, 1'b0);   // R8 touch 1, slave 1
        do_op(5, 1'b0, 8'h00, 8'h01, 1'b0);   // R8 touch 0

        // R10: read-byte request while a write byte is in flight
        keep_byte = rd_byte;
        slave_bits = 8'h00; slave_pres = 1'b0;
        run_cmd(3'd3, 1'b0, 8'h96, 1'b1, cyc);
        verify(3, 1'b0, 8'h96, cyc);
        np_keep = np;
        repeat (20) @(negedge clk);
        #1;
        chk(np == np_keep, "R10 no slot from ignored command", np, np_keep);
        chk(busy == 0, "R10 no command started", int'(busy), 0);
        chk(rd_byte == keep_byte, "R10 rd_byte untouched", int'(rd_byte), int'(keep_byte));

        // R11: unused codes 6 and 7
        for (int c = 6; c < 8; c++) begin
            @(negedge clk); #1;
            np = 0;
            cmd_valid = 1'b1; cmd_op = 3'(c);
            @(negedge clk); #1;
            cmd_valid = 1'b0;
            saw_done = 1'b0;
            for (int t = 0; t < 20; t++) begin
                if (busy || done) saw_done = 1'b1;
                @(negedge clk); #1;
            end
            chk(!saw_done, "R11 unused code no busy or done", int'(saw_done), 0);
            chk(np == 0, "R11 unused code no slot", np, 0);
        end

        // R12: scaled instance
        do_scaled(1'b0);
        do_scaled(1'b1);

        // random mix
        for (int it = 0; it < 14; it++) begin
            int op;
            op = int'($urandom_range(0, 5));
            do_op(op, 1'($urandom), 8'($urandom), 8'($urandom), 1'($urandom));
        end

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule